// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a memory-mapped watchdog for a system clock domain. Software reaches it through a plain 32-bit register port: a byte address, a write strobe, write data, and combinational read data. Four aligned words hold the mode settings, the timing control, a kick location and a status flag. A write to the mode or timing word is kept only if the word carries that register's key pattern. A write that carries no key, or the wrong key, is dropped with no trace. The counter is reloaded only when the kick location receives a specific 16-bit magic value.

The counter counts down once per prescaled tick. The prescaler divides by 8, 64, 512 or 4096. When a tick finds the counter already at zero, the watchdog expires. It then raises a sticky flag and, depending on the mode bits, drives a reset pulse of 2, 4, 8 or 16 clocks, a level interrupt, or both. The control is a four-state machine:

- OFF: disabled.
- COUNT: counting down.
- PULSE: driving the reset pulse.
- EXPIRED: the watchdog has fired and is waiting.

The transitions are:

- Enabling the block moves OFF to COUNT and loads the counter.
- Expiry moves COUNT to PULSE if the reset output is enabled, and to EXPIRED if it is not.
- The pulse running out moves PULSE to EXPIRED.
- A valid kick moves COUNT, PULSE or EXPIRED to COUNT and reloads the counter.
- A keyed clear of the enable bit moves any state to OFF.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, all four words read as zero and both timeout outputs are low.
- R2: A write to offset 0x0 updates the mode fields only when bits [23:12] equal 0xABC. The mode fields are: bit 0 enable, bit 1 reset-output enable, bit 2 interrupt enable, and bits [5:4] pulse-length select. Any other write to 0x0 leaves them unchanged.
- R3: A write to offset 0x4 updates the timing fields only when bits [25:14] equal 0x248. The timing fields are bits [13:2] for the 12-bit reload field and bits [1:0] for the prescaler select.
- R4: Reads return the stored fields at the same bit positions, with all key bits reading zero. Offset 0x8 reads zero. Offset 0xC returns the expiry flag in bit 0.
- R5: The reload value R is the reload field followed by LOW_W one bits. After a keyed write that sets the enable bit, the counter loads on the next clock edge. Expiry then follows (R+1)·D clocks later, where D is the prescale divisor.
- R6: Prescaler select 0, 1, 2 and 3 gives a divisor of 8, 64, 512 and 4096 respectively.
- R7: While enabled, writing 0x1999 in bits [15:0] to offset 0x8 reloads the counter and restarts the prescaler on that edge. Any other value at 0x8 has no effect on the timing.
- R8: If the reset output is enabled, expiry drives timeout_rst high for 2, 4, 8 or 16 clocks, for pulse-length select 0 to 3, starting at the expiry edge.
- R9: Expiry sets the status flag, which stays set with no further action. timeout_irq equals the flag ANDed with the interrupt enable.
- R10: A valid kick after expiry clears the flag on that edge and resumes counting. A keyed write that clears the enable bit stops the block and clears the flag one edge later.
- R11: A kick while the block is disabled has no effect: no expiry, no pulse, and the flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Byte address of the register word |
| wr_en | input | 1 | Write strobe for one clock |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for addr |
| timeout_rst | output | 1 | Reset pulse on expiry |
| timeout_irq | output | 1 | Level interrupt on expiry |

## Verification
A register write appears on readback at the first falling edge after the write edge. An enable takes effect one edge later, because the state machine sees the stored mode bit. Expiry therefore becomes visible 1+(R+1)·D falling edges after the enable write returns, but only (R+1)·D edges after a kick, since a kick acts on its own edge. The bench measures these distances exactly. It also runs a behavioural cycle model that takes inputs on each rising edge, and compares both outputs and the read data against it two time units after every falling edge.

// File: rtl/kw_pkg.sv
package kw_pkg;

    localparam logic [11:0] MODE_KEY = 12'hABC;
    localparam logic [11:0] TIME_KEY = 12'h248;
    localparam logic [15:0] KICK_KEY = 16'h1999;
    localparam int          CRV_W    = 12;
    localparam int          PSEL_N   = 4;
    localparam int          PULSE_W  = 4;

    localparam logic [1:0] OFS_MODE = 2'd0;
    localparam logic [1:0] OFS_TIME = 2'd1;
    localparam logic [1:0] OFS_KICK = 2'd2;
    localparam logic [1:0] OFS_STAT = 2'd3;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_COUNT   = 2'd1,
        ST_PULSE   = 2'd2,
        ST_EXPIRED = 2'd3
    } wd_state_e;

    typedef struct packed {
        logic [1:0] plen;
        logic       irq_en;
        logic       rst_en;
        logic       en;
    } mode_t;

    typedef struct packed {
        logic [CRV_W-1:0] crv;
        logic [1:0]       psel;
    } timing_t;

    // last value of the pulse counter: pulse lasts 2 << sel clocks
    function automatic logic [PULSE_W-1:0] pulse_last(input logic [1:0] sel);
        return PULSE_W'((32'd2 << sel) - 32'd1);
    endfunction

endpackage

// File: rtl/kw_regs.sv
module kw_regs
    import kw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  addr,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        status_q,
    output mode_t       mode_q,
    output timing_t     time_q,
    output logic        kick,
    output logic [31:0] rd_data
);

    logic       aligned;
    logic [1:0] word;
    logic       mode_wr;
    logic       time_wr;
    logic       unused_bits;

    assign aligned     = (addr[1:0] == 2'b00);
    assign word        = addr[3:2];
    assign unused_bits = ^wr_data[31:26];

    // key checks: a write without its key is dropped
    always_comb begin
        mode_wr = wr_en && aligned && (word == OFS_MODE) && (wr_data[23:12] == MODE_KEY);
        time_wr = wr_en && aligned && (word == OFS_TIME) && (wr_data[25:14] == TIME_KEY);
        kick    = wr_en && aligned && (word == OFS_KICK) && (wr_data[15:0]  == KICK_KEY);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            time_q <= '0;
        end else begin
            if (mode_wr) begin
                mode_q.plen   <= wr_data[5:4];
                mode_q.irq_en <= wr_data[2];
                mode_q.rst_en <= wr_data[1];
                mode_q.en     <= wr_data[0];
            end
            if (time_wr) begin
                time_q.crv  <= wr_data[13:2];
                time_q.psel <= wr_data[1:0];
            end
        end
    end

    // readback: key fields always read as zero
    always_comb begin
        rd_data = '0;
        if (aligned) begin
            unique case (word)
                OFS_MODE: rd_data = {26'd0, mode_q.plen, 1'b0, mode_q.irq_en, mode_q.rst_en, mode_q.en};
                OFS_TIME: rd_data = {18'd0, time_q.crv, time_q.psel};
                OFS_KICK: rd_data = '0;
                OFS_STAT: rd_data = {31'd0, status_q};
                default:  rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/kw_prescale.sv
module kw_prescale
    import kw_pkg::*;
#(
    parameter int BASE_SHIFT = 3,
    parameter int STEP_SHIFT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clear,
    input  logic [1:0] psel,
    output logic       tick
);

    localparam int PS_W = BASE_SHIFT + STEP_SHIFT * (PSEL_N - 1);

    logic [PS_W-1:0] ps;
    logic [PS_W-1:0] term [PSEL_N];

    // terminal counts: divisor 2^(BASE_SHIFT + STEP_SHIFT*sel)
    for (genvar g = 0; g < PSEL_N; g++) begin : g_term
        assign term[g] = PS_W'((64'd1 << (BASE_SHIFT + STEP_SHIFT * g)) - 64'd1);
    end

    assign tick = run && (ps >= term[psel]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps <= '0;
        end else if (!run || clear || tick) begin
            ps <= '0;
        end else begin
            ps <= ps + 1'b1;
        end
    end

endmodule

// File: rtl/kw_core.sv
module kw_core
    import kw_pkg::*;
#(
    parameter int LOW_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  mode_t                  mode_q,
    input  logic [CRV_W-1:0]       crv,
    input  logic                   kick,
    input  logic                   tick,
    output wd_state_e              st,
    output logic [CRV_W+LOW_W-1:0] cnt,
    output logic                   run,
    output logic                   status_q,
    output logic                   timeout_rst,
    output logic                   timeout_irq
);

    localparam int CNT_W = CRV_W + LOW_W;

    wd_state_e          nxt;
    logic               load;
    logic               expire;
    logic [PULSE_W-1:0] pcnt;
    logic [CNT_W-1:0]   reload;

    assign reload = {crv, {LOW_W{1'b1}}};
    assign expire = tick && (cnt == '0);

    // next-state logic
    always_comb begin
        nxt  = st;
        load = 1'b0;
        unique case (st)
            ST_OFF: begin
                if (mode_q.en) begin
                    nxt  = ST_COUNT;
                    load = 1'b1;
                end
            end
            ST_COUNT: begin
                if (!mode_q.en) begin
                    nxt = ST_OFF;
                end else if (kick) begin
                    load = 1'b1;
                end else if (expire) begin
                    nxt = mode_q.rst_en ? ST_PULSE : ST_EXPIRED;
                end
            end
            ST_PULSE: begin
                if (!mode_q.en) begin
                    nxt = ST_OFF;
                end else if (kick) begin
                    nxt  = ST_COUNT;
                    load = 1'b1;
                end else if (pcnt == '0) begin
                    nxt = ST_EXPIRED;
                end
            end
            ST_EXPIRED: begin
                if (!mode_q.en) begin
                    nxt = ST_OFF;
                end else if (kick) begin
                    nxt  = ST_COUNT;
                    load = 1'b1;
                end
            end
            default: nxt = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_OFF;
        end else begin
            st <= nxt;
        end
    end

    // counter, pulse length and sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            pcnt     <= '0;
            status_q <= 1'b0;
        end else begin
            if (load) begin
                cnt <= reload;
            end else if ((st == ST_COUNT) && tick && (cnt != '0)) begin
                cnt <= cnt - 1'b1;
            end

            if ((st != ST_PULSE) && (nxt == ST_PULSE)) begin
                pcnt <= pulse_last(mode_q.plen);
            end else if ((st == ST_PULSE) && (pcnt != '0)) begin
                pcnt <= pcnt - 1'b1;
            end

            status_q <= (nxt == ST_PULSE) || (nxt == ST_EXPIRED);
        end
    end

    // outputs
    always_comb begin
        run         = (st == ST_COUNT);
        timeout_rst = (st == ST_PULSE);
        timeout_irq = status_q && mode_q.irq_en;
    end

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kw_pkg::*;
#(
    parameter int LOW_W      = 12,
    parameter int BASE_SHIFT = 3,
    parameter int STEP_SHIFT = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  addr,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        timeout_rst,
    output logic        timeout_irq
);

    localparam int CNT_W = CRV_W + LOW_W;

    mode_t            mode_q;
    timing_t          time_q;
    logic             kick;
    logic             tick;
    logic             run;
    logic             status_q;
    wd_state_e        st;
    logic [CNT_W-1:0] cnt;

    kw_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .status_q (status_q),
        .mode_q   (mode_q),
        .time_q   (time_q),
        .kick     (kick),
        .rd_data  (rd_data)
    );

    kw_prescale #(
        .BASE_SHIFT (BASE_SHIFT),
        .STEP_SHIFT (STEP_SHIFT)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clear (kick),
        .psel  (time_q.psel),
        .tick  (tick)
    );

    kw_core #(
        .LOW_W (LOW_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_q      (mode_q),
        .crv         (time_q.crv),
        .kick        (kick),
        .tick        (tick),
        .st          (st),
        .cnt         (cnt),
        .run         (run),
        .status_q    (status_q),
        .timeout_rst (timeout_rst),
        .timeout_irq (timeout_irq)
    );

endmodule

// File: rtl/kw_checker.sv
module kw_checker
    import kw_pkg::*;
#(
    parameter int LOW_W = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [3:0]             addr,
    input logic                   wr_en,
    input logic [31:0]            wr_data,
    input mode_t                  mode_q,
    input timing_t                time_q,
    input logic                   kick,
    input logic                   tick,
    input wd_state_e              st,
    input logic [CRV_W+LOW_W-1:0] cnt,
    input logic                   status_q,
    input logic                   timeout_rst
);

    localparam logic [LOW_W-1:0] ONES = '1;

    logic [4:0] hi_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_len <= '0;
        end else begin
            hi_len <= timeout_rst ? hi_len + 5'd1 : 5'd0;
        end
    end

    assert_unkeyed_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'h0 && wr_data[23:12] != MODE_KEY) |=> $stable(mode_q));

    assert_unkeyed_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'h4 && wr_data[25:14] != TIME_KEY) |=> $stable(time_q));

    assert_kick_reloads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && mode_q.en) |=> (st == ST_COUNT) && (cnt == {$past(time_q.crv), ONES}));

    assert_expiry_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COUNT && tick && cnt == '0 && mode_q.en && !kick) |=> status_q);

    assert_flag_needs_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q) |-> ($past(tick) && $past(cnt) == '0));

    assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q.en |=> (!status_q && !timeout_rst));

    assert_pulse_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_rst |-> (hi_len < 5'd16));

    assert_kick_off_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && st == ST_OFF && !mode_q.en) |=> (st == ST_OFF && cnt == $past(cnt)));

endmodule

bind keyed_watchdog kw_checker #(.LOW_W(LOW_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .mode_q      (mode_q),
    .time_q      (time_q),
    .kick        (kick),
    .tick        (tick),
    .st          (st),
    .cnt         (cnt),
    .status_q    (status_q),
    .timeout_rst (timeout_rst)
);

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;

    localparam int CLK_PERIOD = 10;
    localparam int LOW_W      = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = 4'hC;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        timeout_rst;
    logic        timeout_irq;

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    keyed_watchdog #(.LOW_W(LOW_W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (addr),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .timeout_rst (timeout_rst),
        .timeout_irq (timeout_irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference model: 0 off, 1 count, 2 pulse, 3 expired
    int m_en, m_rsten, m_irqen, m_plen, m_crv, m_psel;
    int m_st, m_cnt, m_ps, m_pc, m_stat;

    always @(posedge clk) begin
        int div, rl, ns, nc, nps, npc;
        bit kk, tk, ld;
        if (!rst_n) begin
            m_en = 0; m_rsten = 0; m_irqen = 0; m_plen = 0; m_crv = 0; m_psel = 0;
            m_st = 0; m_cnt = 0; m_ps = 0; m_pc = 0; m_stat = 0;
        end else begin
            div = 8 << (3 * m_psel);
            rl  = m_crv * (1 << LOW_W) + (1 << LOW_W) - 1;
            kk  = wr_en && addr == 4'h8 && wr_data[15:0] == 16'h1999;
            tk  = (m_st == 1) && (m_ps >= div - 1);
            ns = m_st; ld = 0;
            if (m_st == 0) begin
                if (m_en != 0) begin ns = 1; ld = 1; end
            end else if (m_en == 0) begin
                ns = 0;
            end else if (kk) begin
                ns = 1; ld = 1;
            end else if (m_st == 1 && tk && m_cnt == 0) begin
                ns = (m_rsten != 0) ? 2 : 3;
            end else if (m_st == 2 && m_pc == 0) begin
                ns = 3;
            end
            nps = (m_st != 1 || kk || tk) ? 0 : m_ps + 1;
            nc  = ld ? rl : ((m_st == 1 && tk && m_cnt != 0) ? m_cnt - 1 : m_cnt);
            npc = (m_st != 2 && ns == 2) ? (2 << m_plen) - 1 : ((m_st == 2 && m_pc != 0) ? m_pc - 1 : m_pc);
            m_stat = (ns == 2 || ns == 3) ? 1 : 0;
            m_st = ns; m_cnt = nc; m_ps = nps; m_pc = npc;
            if (wr_en && addr == 4'h0 && wr_data[23:12] == 12'hABC) begin
                m_en = wr_data[0]; m_rsten = wr_data[1]; m_irqen = wr_data[2]; m_plen = int'(wr_data[5:4]);
            end
            if (wr_en && addr == 4'h4 && wr_data[25:14] == 12'h248) begin
                m_crv = int'(wr_data[13:2]); m_psel = int'(wr_data[1:0]);
            end
        end
    end

    always @(negedge clk) begin
        int erd;
        #2;
        if (rst_n && !finished) begin
            case (addr)
                4'h0:    erd = (m_plen << 4) | (m_irqen << 2) | (m_rsten << 1) | m_en;
                4'h4:    erd = (m_crv << 2) | m_psel;
                4'hC:    erd = m_stat;
                default: erd = 0;
            endcase
            chk("R8 model timeout_rst", timeout_rst, (m_st == 2) ? 1 : 0);
            chk("R9 model timeout_irq", timeout_irq, (m_stat != 0 && m_irqen != 0) ? 1 : 0);
            chk("R4 model rd_data", rd_data, erd);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    function automatic logic [31:0] mode_w(input int en, input int rs, input int iq, input int pl);
        return 32'h00ABC000 | 32'(pl << 4) | 32'(iq << 2) | 32'(rs << 1) | 32'(en);
    endfunction

    function automatic logic [31:0] time_w(input int crv, input int ps);
        return 32'h00920000 | 32'(crv << 2) | 32'(ps);
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; addr = 4'hC;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_irq(inout int n);
        while (!timeout_irq && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        logic [31:0] v;
        int n;
        int len;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(4'h0, v); chk("R1 mode after reset", v, 0);
        rd(4'h4, v); chk("R1 timing after reset", v, 0);
        rd(4'hC, v); chk("R1 status after reset", v, 0);
        chk("R1 outputs after reset", {timeout_rst, timeout_irq}, 0);

        // R2: key on mode word
        wr(4'h0, 32'h00ABD001);
        rd(4'h0, v); chk("R2 unkeyed mode dropped", v, 0);
        wr(4'h0, mode_w(0, 0, 1, 3));
        rd(4'h0, v); chk("R2 R4 keyed mode readback", v, 32'h34);

        // R3: key on timing word
        wr(4'h4, 32'h00930016);
        rd(4'h4, v); chk("R3 unkeyed timing dropped", v, 0);
        wr(4'h4, time_w(5, 2));
        rd(4'h4, v); chk("R3 R4 keyed timing readback", v, 32'h16);
        rd(4'h8, v); chk("R4 kick word reads zero", v, 0);
        wr(4'h4, time_w(0, 0));

        // R11: kicks while disabled
        wr(4'h8, 32'h1999);
        wr(4'h8, 32'h1999);
        repeat (200) @(negedge clk);
        chk("R11 no pulse while off", timeout_rst, 0);
        rd(4'hC, v); chk("R11 flag clear while off", v, 0);

        // R5 R9: enable, measure expiry (R=15, D=8)
        wr(4'h0, mode_w(1, 0, 1, 0));
        n = 0; wait_irq(n);
        chk("R5 enable to expiry", n, 1 + 16 * 8);
        repeat (50) @(negedge clk);
        rd(4'hC, v); chk("R9 flag sticky", v, 1);

        // R10: kick after expiry clears flag
        wr(4'h8, 32'h1999);
        chk("R10 kick clears irq", timeout_irq, 0);
        n = 0;
        repeat (30) @(negedge clk);
        n += 30;
        wr(4'h8, 32'h00011998);
        n += 2;
        wait_irq(n);
        chk("R7 bad kick value ignored", n, 16 * 8);

        // R7: mid-count kick reloads
        wr(4'h8, 32'h1999);
        repeat (60) @(negedge clk);
        wr(4'h8, 32'h1999);
        n = 0; wait_irq(n);
        chk("R7 kick reloads counter", n, 16 * 8);

        // R10: disable clears flag one edge later
        wr(4'h0, mode_w(0, 0, 1, 0));
        rd(4'hC, v); chk("R10 disable clears flag", v, 0);
        repeat (300) @(negedge clk);
        chk("R10 stays quiet when off", timeout_irq, 0);

        // R8: reset pulse length 16 then 2
        wr(4'h0, mode_w(1, 1, 0, 3));
        n = 0;
        while (!timeout_rst && n < 5000) begin @(negedge clk); n++; end
        chk("R8 enable to pulse", n, 1 + 16 * 8);
        len = 0;
        while (timeout_rst && len < 100) begin @(negedge clk); len++; end
        chk("R8 pulse length sel3", len, 16);
        chk("R9 irq masked when disabled", timeout_irq, 0);
        rd(4'hC, v); chk("R9 flag set on expiry", v, 1);
        wr(4'h0, mode_w(0, 1, 0, 0));
        wr(4'h0, mode_w(1, 1, 0, 0));
        n = 0;
        while (!timeout_rst && n < 5000) begin @(negedge clk); n++; end
        len = 0;
        while (timeout_rst && len < 100) begin @(negedge clk); len++; end
        chk("R8 pulse length sel0", len, 2);

        // R6: divide by 64
        wr(4'h0, mode_w(0, 0, 1, 0));
        wr(4'h4, time_w(0, 1));
        wr(4'h0, mode_w(1, 0, 1, 0));
        n = 0; wait_irq(n);
        chk("R6 divide by 64", n, 1 + 16 * 64);

        // R5: reload field scaling
        wr(4'h0, mode_w(0, 0, 1, 0));
        wr(4'h4, time_w(1, 0));
        wr(4'h0, mode_w(1, 0, 1, 0));
        n = 0; wait_irq(n);
        chk("R5 reload field one", n, 1 + 32 * 8);

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule